// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor core that completes one instruction in every clock cycle. It handles a small load/store subset: word loads and stores, register-to-register add, subtract, AND, OR and signed set-less-than, branch-if-equal and an unconditional jump. Instruction and data storage are separate word arrays inside the core, so fetch and data access can happen in the same cycle.

A control decoder turns the opcode into a packed set of strobes for the datapath. Operation selection is decoded in two levels. The main decoder produces a two-bit operation class. A second decoder combines that class with the function field to pick the ALU operation. Each cycle the next program counter is chosen from three values: the sequential address, the branch target or the jump target.

Both arrays are loaded through a simple programming port before execution starts, normally while reset is held. The architectural effects of every cycle can be seen on the trace outputs: the program counter, the fetched instruction, the register write and the memory write.

Top module: `scpu_core`

## Requirements
- R1: While `rst` is high, the core does not write a register or data memory. On each rising edge with `rst` high, the program counter becomes 0.
- R2: Opcode 0 is a register-format operation. Function codes are: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR. The operands come from the registers in bits 25:21 and 20:16. The result is written to the register in bits 15:11.
- R3: Register-format function 0x2A writes 1 when the first operand is less than the second in a signed comparison, and 0 otherwise.
- R4: Opcode 35 (load) writes data memory word `(rs + signext(imm16))[7:2]` into the register in bits 20:16.
- R5: Opcode 43 (store) writes the register in bits 20:16 to data memory at `rs + signext(imm16)`. It writes no register. A register write and a memory write never occur in the same cycle.
- R6: Opcode 4 (branch) compares the two read registers. If they are equal, the next PC is PC+4 plus the sign-extended 16-bit offset shifted left by 2. Otherwise the next PC is PC+4.
- R7: Opcode 2 (jump) sets the next PC to the upper 4 bits of PC+4, then bits 25:0 of the instruction, then two zero bits.
- R8: Register 0 always reads as zero. A write to register 0 has no effect.
- R9: Any opcode other than 0, 2, 4, 35 and 43 is a no-op: no register write, no memory write, and the next PC is PC+4. Every instruction that is not a branch or a jump also advances the PC by 4.
- R10: When `progWe` is high, a rising edge writes `progData` to word `progAddr`. The target is instruction memory when `progToData` is 0 and data memory when it is 1. Fetch reads the word at PC[7:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| progWe | input | 1 | Programming write strobe |
| progToData | input | 1 | Programming target: 0 instruction memory, 1 data memory |
| progAddr | input | 6 | Programming word address |
| progData | input | 32 | Programming write data |
| pcOut | output | 32 | Current program counter |
| instrOut | output | 32 | Instruction fetched at the current PC |
| regWrEn | output | 1 | Register write occurs at the next edge |
| regWrAddr | output | 5 | Register being written |
| regWrData | output | 32 | Value being written to the register |
| memWrEn | output | 1 | Data memory write occurs at the next edge |
| memAddr | output | 32 | Data memory byte address (ALU result) |
| memWrData | output | 32 | Data being stored |

## Verification
The bound checker checks these properties on every cycle:
- the PC is cleared during reset and no writes occur while reset is held;
- a register write and a memory write never coincide;
- unknown opcodes are silent;
- a load always targets the rt field;
- every non-transfer instruction advances the PC by four;
- a branch lands on either the fall-through address or the offset target;
- a jump lands on the concatenated target.

Whether a branch should be taken, the arithmetic results, signed ordering in slt, and the fact that register 0 stays zero are checked by the bench. It runs a preloaded program through a behavioural instruction-level model and compares every cycle. A second reset in the middle of the run checks that execution restarts from address zero.

// File: rtl/scpu_pkg.sv
package scpu_pkg;
  localparam int XLEN = 32;
  localparam int REG_COUNT = 32;
  localparam int REG_AW = $clog2(REG_COUNT);

  typedef enum logic [5:0] {
    OP_RTYPE = 6'd0,
    OP_JUMP  = 6'd2,
    OP_BEQ   = 6'd4,
    OP_LOAD  = 6'd35,
    OP_STORE = 6'd43
  } opcode_e;

  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } opclass_e;

  typedef enum logic [2:0] {
    SEL_AND = 3'b000,
    SEL_OR  = 3'b001,
    SEL_ADD = 3'b010,
    SEL_SUB = 3'b110,
    SEL_SLT = 3'b111
  } alusel_e;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic     destFromRd;
    logic     useImm;
    logic     wbFromMem;
    logic     regWrite;
    logic     memRead;
    logic     memWrite;
    logic     branch;
    logic     jump;
    opclass_e opClass;
  } ctrl_t;
endpackage

// File: rtl/scpu_control.sv
module scpu_control
  import scpu_pkg::*;
(
  input  logic [5:0] opcode,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '{destFromRd: 1'b0, useImm: 1'b0, wbFromMem: 1'b0, regWrite: 1'b0,
             memRead: 1'b0, memWrite: 1'b0, branch: 1'b0, jump: 1'b0,
             opClass: CLS_ADD};
    case (opcode)
      OP_RTYPE: begin
        ctrl.destFromRd = 1'b1;
        ctrl.regWrite   = 1'b1;
        ctrl.opClass    = CLS_FUNCT;
      end
      OP_LOAD: begin
        ctrl.useImm    = 1'b1;
        ctrl.wbFromMem = 1'b1;
        ctrl.regWrite  = 1'b1;
        ctrl.memRead   = 1'b1;
      end
      OP_STORE: begin
        ctrl.useImm   = 1'b1;
        ctrl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctrl.branch  = 1'b1;
        ctrl.opClass = CLS_SUB;
      end
      OP_JUMP: begin
        ctrl.jump = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
  import scpu_pkg::*;
(
  input  opclass_e         opClass,
  input  logic [5:0]       funct,
  input  logic [XLEN-1:0]  opA,
  input  logic [XLEN-1:0]  opB,
  output logic [XLEN-1:0]  result,
  output logic             zero
);
  alusel_e sel;

  // second decode level: class plus function field
  always_comb begin
    case (opClass)
      CLS_ADD: sel = SEL_ADD;
      CLS_SUB: sel = SEL_SUB;
      default: begin
        case (funct)
          FN_ADD:  sel = SEL_ADD;
          FN_SUB:  sel = SEL_SUB;
          FN_AND:  sel = SEL_AND;
          FN_OR:   sel = SEL_OR;
          FN_SLT:  sel = SEL_SLT;
          default: sel = SEL_ADD;
        endcase
      end
    endcase
  end

  always_comb begin
    case (sel)
      SEL_AND: result = opA & opB;
      SEL_OR:  result = opA | opB;
      SEL_SUB: result = opA - opB;
      SEL_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = opA + opB;
    endcase
  end

  assign zero = (result == '0);
endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile
  import scpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData
);
  logic [XLEN-1:0] regs [REG_COUNT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REG_COUNT; i++) regs[i] <= '0;
    end else if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];
endmodule

// File: rtl/scpu_datapath.sv
module scpu_datapath
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int PROG_AW    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic               progWe,
  input  logic               progToData,
  input  logic [PROG_AW-1:0] progAddr,
  input  logic [XLEN-1:0]    progData,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    instr,
  output logic               regWrEn,
  output logic [REG_AW-1:0]  regWrAddr,
  output logic [XLEN-1:0]    regWrData,
  output logic               memWrEn,
  output logic [XLEN-1:0]    memAddr,
  output logic [XLEN-1:0]    memWrData
);
  localparam int IMEM_AW = $clog2(IMEM_WORDS);
  localparam int DMEM_AW = $clog2(DMEM_WORDS);

  logic [XLEN-1:0] imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  logic [XLEN-1:0] pcPlus4, branchTarget, jumpTarget, pcNext;
  logic [XLEN-1:0] immExt, rsData, rtData, aluB, aluResult, memRdData;
  logic            aluZero;

  // program load port
  always_ff @(posedge clk) begin
    if (progWe && !progToData) imem[progAddr[IMEM_AW-1:0]] <= progData;
  end

  always_ff @(posedge clk) begin
    if (progWe && progToData) dmem[progAddr[DMEM_AW-1:0]] <= progData;
    else if (memWrEn)         dmem[aluResult[2 +: DMEM_AW]] <= rtData;
  end

  assign instr = imem[pc[2 +: IMEM_AW]];

  assign immExt = {{(XLEN-16){instr[15]}}, instr[15:0]};

  scpu_regfile regfile_i (
    .clk     (clk),
    .rst     (rst),
    .rdAddrA (instr[25:21]),
    .rdAddrB (instr[20:16]),
    .rdDataA (rsData),
    .rdDataB (rtData),
    .wrEn    (regWrEn),
    .wrAddr  (regWrAddr),
    .wrData  (regWrData)
  );

  assign aluB = ctrl.useImm ? immExt : rtData;

  scpu_alu alu_i (
    .opClass (ctrl.opClass),
    .funct   (instr[5:0]),
    .opA     (rsData),
    .opB     (aluB),
    .result  (aluResult),
    .zero    (aluZero)
  );

  assign memRdData = ctrl.memRead ? dmem[aluResult[2 +: DMEM_AW]] : '0;

  // write-back and store strobes, held off during reset
  assign regWrEn   = ctrl.regWrite & ~rst;
  assign regWrAddr = ctrl.destFromRd ? instr[15:11] : instr[20:16];
  assign regWrData = ctrl.wbFromMem ? memRdData : aluResult;
  assign memWrEn   = ctrl.memWrite & ~rst;
  assign memAddr   = aluResult;
  assign memWrData = rtData;

  // next-PC selection from three sources
  assign pcPlus4      = pc + 32'd4;
  assign branchTarget = pcPlus4 + {immExt[XLEN-3:0], 2'b00};
  assign jumpTarget   = {pcPlus4[XLEN-1:XLEN-4], instr[25:0], 2'b00};

  always_comb begin
    if (ctrl.jump)                   pcNext = jumpTarget;
    else if (ctrl.branch && aluZero) pcNext = branchTarget;
    else                             pcNext = pcPlus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pcNext;
  end
endmodule

// File: rtl/scpu_core.sv
module scpu_core
  import scpu_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int PROG_AW    = (IMEM_WORDS > DMEM_WORDS) ? $clog2(IMEM_WORDS) : $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               progWe,
  input  logic               progToData,
  input  logic [PROG_AW-1:0] progAddr,
  input  logic [31:0]        progData,
  output logic [31:0]        pcOut,
  output logic [31:0]        instrOut,
  output logic               regWrEn,
  output logic [4:0]         regWrAddr,
  output logic [31:0]        regWrData,
  output logic               memWrEn,
  output logic [31:0]        memAddr,
  output logic [31:0]        memWrData
);
  ctrl_t ctrl;

  scpu_control control_i (
    .opcode (instrOut[31:26]),
    .ctrl   (ctrl)
  );

  scpu_datapath #(
    .IMEM_WORDS (IMEM_WORDS),
    .DMEM_WORDS (DMEM_WORDS),
    .PROG_AW    (PROG_AW)
  ) datapath_i (
    .clk        (clk),
    .rst        (rst),
    .ctrl       (ctrl),
    .progWe     (progWe),
    .progToData (progToData),
    .progAddr   (progAddr),
    .progData   (progData),
    .pc         (pcOut),
    .instr      (instrOut),
    .regWrEn    (regWrEn),
    .regWrAddr  (regWrAddr),
    .regWrData  (regWrData),
    .memWrEn    (memWrEn),
    .memAddr    (memAddr),
    .memWrData  (memWrData)
  );
endmodule

// File: rtl/scpu_core_checker.sv
module scpu_core_checker
  import scpu_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] pcOut,
  input logic [31:0] instrOut,
  input logic        regWrEn,
  input logic [4:0]  regWrAddr,
  input logic        memWrEn,
  input ctrl_t       ctrl
);
  logic prevRst;
  logic knownOp;

  always_ff @(posedge clk) prevRst <= rst;

  assign knownOp = (instrOut[31:26] == 6'd0) || (instrOut[31:26] == 6'd2) ||
                   (instrOut[31:26] == 6'd4) || (instrOut[31:26] == 6'd35) ||
                   (instrOut[31:26] == 6'd43);

  // R1: the PC reads zero after any edge taken in reset; no writes in reset
  always @(negedge clk) begin
    if (prevRst === 1'b1) begin
      assert_pc_reset_R1: assert (pcOut == 32'd0);
    end
    if (rst === 1'b1) begin
      assert_quiet_reset_R1: assert (!regWrEn && !memWrEn);
    end
  end

  assert_write_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(regWrEn && memWrEn));

  assert_unknown_silent_R9: assert property (@(posedge clk) disable iff (rst)
    !knownOp |-> (!regWrEn && !memWrEn));

  assert_load_dest_R4: assert property (@(posedge clk) disable iff (rst)
    ctrl.memRead |-> (regWrEn && regWrAddr == instrOut[20:16]));

  assert_seq_pc_R9: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.branch && !ctrl.jump) |=> pcOut == $past(pcOut) + 32'd4);

  assert_branch_dest_R6: assert property (@(posedge clk) disable iff (rst)
    ctrl.branch |=> (pcOut == $past(pcOut) + 32'd4) ||
                    (pcOut == $past(pcOut) + 32'd4 +
                      {{14{$past(instrOut[15])}}, $past(instrOut[15:0]), 2'b00}));

  assert_jump_dest_R7: assert property (@(posedge clk) disable iff (rst)
    ctrl.jump |=> pcOut == {$past(pcOut[31:28]), $past(instrOut[25:0]), 2'b00});
endmodule

bind scpu_core scpu_core_checker checker_i (
  .clk       (clk),
  .rst       (rst),
  .pcOut     (pcOut),
  .instrOut  (instrOut),
  .regWrEn   (regWrEn),
  .regWrAddr (regWrAddr),
  .memWrEn   (memWrEn),
  .ctrl      (ctrl)
);

// File: tb/scpu_core_tb_top.sv
module scpu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WORDS = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        progWe = 1'b0;
  logic        progToData = 1'b0;
  logic [5:0]  progAddr = '0;
  logic [31:0] progData = '0;
  logic [31:0] pcOut, instrOut, regWrData, memAddr, memWrData;
  logic        regWrEn, memWrEn;
  logic [4:0]  regWrAddr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [31:0] mImem [WORDS];
  logic [31:0] mDmem [WORDS];
  logic [31:0] mRegs [32];
  logic [31:0] mPc;
  string       pcTag;

  always #(CLK_PERIOD/2) clk = ~clk;

  scpu_core dut_i (
    .clk (clk), .rst (rst), .progWe (progWe), .progToData (progToData),
    .progAddr (progAddr), .progData (progData), .pcOut (pcOut),
    .instrOut (instrOut), .regWrEn (regWrEn), .regWrAddr (regWrAddr),
    .regWrData (regWrData), .memWrEn (memWrEn), .memAddr (memAddr),
    .memWrData (memWrData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h (pc model %h)", req, what, act, exp, mPc);
    end
  endtask

  function automatic logic [31:0] encR(int rs, int rt, int rd, logic [5:0] fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] encI(logic [5:0] op, int rs, int rt, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction
  function automatic logic [31:0] encJ(int word);
    return {6'd2, 26'(word)};
  endfunction

  // Behavioural instruction model: compare current cycle, then advance
  task automatic compareAndStep();
    logic [31:0] ins, a, b, imm, res, nextPc;
    logic [5:0]  op;
    bit          expRegWe, expMemWe;
    logic [4:0]  expRegAddr;
    logic [31:0] expRegData;
    string       tag;
    ins = mImem[mPc[7:2]];
    op  = ins[31:26];
    a   = (ins[25:21] == 0) ? 32'd0 : mRegs[ins[25:21]];
    b   = (ins[20:16] == 0) ? 32'd0 : mRegs[ins[20:16]];
    imm = {{16{ins[15]}}, ins[15:0]};
    expRegWe = 0; expMemWe = 0; expRegAddr = 0; expRegData = 0;
    nextPc = mPc + 4;
    tag = "R9";
    check(pcOut == mPc, pcTag, "pc", pcOut, mPc);
    check(instrOut == ins, "R10", "fetched word", instrOut, ins);
    if (op == 6'd0) begin
      tag = ((ins[25:21] == 0) || (ins[20:16] == 0) || (ins[15:11] == 0)) ? "R8" : "R2";
      case (ins[5:0])
        6'h22: res = a - b;
        6'h24: res = a & b;
        6'h25: res = a | b;
        6'h2A: begin res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
        default: res = a + b;
      endcase
      expRegWe = 1; expRegAddr = ins[15:11]; expRegData = res;
    end else if (op == 6'd35) begin
      tag = "R4";
      res = a + imm;
      expRegWe = 1; expRegAddr = ins[20:16]; expRegData = mDmem[res[7:2]];
    end else if (op == 6'd43) begin
      tag = "R5";
      res = a + imm;
      expMemWe = 1;
      check(memWrEn == 1'b1, tag, "store strobe", 32'(memWrEn), 32'd1);
      check(memAddr == res, tag, "store address", memAddr, res);
      check(memWrData == b, tag, "store data", memWrData, b);
      mDmem[res[7:2]] = b;
    end else if (op == 6'd4) begin
      tag = "R6";
      if (a == b) nextPc = mPc + 4 + {imm[29:0], 2'b00};
    end else if (op == 6'd2) begin
      tag = "R7";
      nextPc = {mPc[31:28] + 4'd0, ins[25:0], 2'b00};
      nextPc[31:28] = (mPc + 32'd4) >> 28;
    end
    check(regWrEn == expRegWe, tag, "register write strobe", 32'(regWrEn), 32'(expRegWe));
    if (!expMemWe)
      check(memWrEn == 1'b0, tag, "no store strobe", 32'(memWrEn), 32'd0);
    if (expRegWe) begin
      check(regWrAddr == expRegAddr, tag, "write register", 32'(regWrAddr), 32'(expRegAddr));
      check(regWrData == expRegData, tag, "write data", regWrData, expRegData);
      if (expRegAddr != 0) mRegs[expRegAddr] = expRegData;
    end
    pcTag = tag;
    mPc = nextPc;
  endtask

  task automatic runCycles(input int n);
    for (int i = 0; i < n; i++) begin
      #1;
      compareAndStep();
      @(negedge clk);
    end
  endtask

  task automatic resetModel();
    for (int i = 0; i < 32; i++) mRegs[i] = 32'd0;
    mPc = 32'd0;
    pcTag = "R1";
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) begin mImem[i] = 32'd0; mDmem[i] = 32'd0; end
    mImem[0]  = encI(6'd35, 0, 1, 0);        // r1 = 5
    mImem[1]  = encI(6'd35, 0, 2, 4);        // r2 = -3
    mImem[2]  = encI(6'd35, 0, 3, 8);        // r3 = pattern
    mImem[3]  = encR(1, 2, 4, 6'h20);        // r4 = 2
    mImem[4]  = encR(2, 1, 5, 6'h22);        // r5 = -8
    mImem[5]  = encR(3, 1, 6, 6'h24);
    mImem[6]  = encR(3, 2, 7, 6'h25);
    mImem[7]  = encR(2, 1, 8, 6'h2A);        // signed: 1
    mImem[8]  = encR(1, 2, 9, 6'h2A);        // signed: 0
    mImem[9]  = encR(1, 1, 0, 6'h20);        // write to r0 dropped
    mImem[10] = encR(0, 1, 10, 6'h20);       // r10 = 0 + 5
    mImem[11] = encI(6'd43, 1, 4, 7);        // mem[12] = r4
    mImem[12] = encI(6'd35, 0, 11, 12);      // r11 = 2
    mImem[13] = encI(6'd4, 1, 2, 5);         // not taken
    mImem[14] = encI(6'd4, 11, 4, 2);        // taken to word 17
    mImem[15] = encR(1, 1, 12, 6'h20);
    mImem[16] = encR(1, 1, 12, 6'h20);
    mImem[17] = {6'h3F, 26'h3FF_FFFF};       // unknown opcode
    mImem[18] = encJ(22);
    mImem[19] = encR(1, 1, 13, 6'h20);
    mImem[20] = encI(6'd35, 1, 14, -5);      // negative offset load
    mImem[21] = encJ(23);
    mImem[22] = encI(6'd4, 0, 0, -3);        // backward branch to 20
    mImem[23] = encJ(23);
    mDmem[0] = 32'd5;
    mDmem[1] = 32'hFFFF_FFFD;
    mDmem[2] = 32'h0F0F_00FF;
    mDmem[3] = 32'd7;
    resetModel();

    @(negedge clk);
    for (int i = 0; i < WORDS; i++) begin
      progWe = 1; progToData = 0; progAddr = 6'(i); progData = mImem[i];
      @(negedge clk);
    end
    for (int i = 0; i < 4; i++) begin
      progWe = 1; progToData = 1; progAddr = 6'(i); progData = mDmem[i];
      @(negedge clk);
    end
    progWe = 0;
    #1;
    check(pcOut == 32'd0, "R1", "pc in reset", pcOut, 32'd0);
    check(regWrEn == 1'b0, "R1", "register write in reset", 32'(regWrEn), 32'd0);
    check(memWrEn == 1'b0, "R1", "store in reset", 32'(memWrEn), 32'd0);
    @(negedge clk);
    rst = 0;
    runCycles(40);

    // second reset in the middle of the idle loop
    rst = 1;
    @(negedge clk);
    #1;
    check(pcOut == 32'd0, "R1", "pc after mid-run reset", pcOut, 32'd0);
    check(regWrEn == 1'b0 && memWrEn == 1'b0, "R1", "writes in reset",
          {30'd0, regWrEn, memWrEn}, 32'd0);
    @(negedge clk);
    rst = 0;
    resetModel();
    runCycles(30);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule